// File: doc/BRIEF.md
# Register Scoreboard Wakeup Unit

This block tracks whether each physical register (integer and floating-point counted together) holds a valid result, and it keeps, for every occupied instruction slot, the tags of the source operands that the slot still waits for. A new instruction enters a slot with its destination tag, its source tags and a per-source flag that says whether the renamer believed that source to be unready. The destination is marked not ready. An unready source is checked against the scoreboard as it arrives. If the register has become ready since renaming, the source is taken as ready and no waiter is recorded.

When a producer completes, its destination tag is broadcast across the slots. Every slot source that waits on that tag gets a one-cycle wake pulse and becomes ready, and the scoreboard bit is set. A slot whose sources are all ready drives its ready line to the issue logic. A kill mask drops slots and their waiters. When a new producer claims a register that still has waiters, an error line is raised. Tags at or above the physical register count are outside the tracked range and are ignored.

Top module: `sbw_wakeup_unit`

## Requirements
- R1: After reset every scoreboard bit is 0 (not ready) and every `ready_o` bit is 0.
- R2: An insert whose destination tag is below NUM_PREGS clears that scoreboard bit at the next edge. This also holds when a completion of the same tag falls in the same cycle.
- R3: A completion whose tag is below NUM_PREGS sets that scoreboard bit at the next edge.
- R4: At insert, a source is ready at once in two cases: its unready flag is 0, or its scoreboard bit is already 1. Only other sources wait.
- R5: Tags at or above NUM_PREGS are ignored. Such a destination changes no scoreboard bit, such a source is ready at once, and such a completion wakes nothing and sets no bit.
- R6: In a cycle with an in-range completion, `wake_o[e*NUM_SRCS+s]` is 1 exactly when slot e is occupied, is not killed that cycle, and its source s waits on the completed tag. That source is ready from the next edge on.
- R7: `ready_o[e]` is 1 exactly when slot e is occupied and all its sources are ready.
- R8: A slot set in `kill_mask_i` is empty from the next edge on: its ready line is 0 and it receives no wake. An insert to the same slot in the same cycle takes precedence over the kill.
- R9: `err_o` is 1 in a cycle with an insert whose in-range destination tag is awaited by some source of an occupied slot.
- R10: An unready source whose tag equals the tag of an in-range completion in the same cycle is inserted as ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Insert an instruction this cycle |
| alloc_idx_i | input | IDX_W | Slot that receives the instruction |
| alloc_dst_i | input | TAG_W | Destination register tag |
| alloc_src_tags_i | input | NUM_SRCS*TAG_W | Source tags; source s at bits s*TAG_W upward |
| alloc_src_unrdy_i | input | NUM_SRCS | Per source: 1 means the renamer saw it unready |
| cmpl_valid_i | input | 1 | A producer completes this cycle |
| cmpl_tag_i | input | TAG_W | Destination tag of the completing producer |
| kill_mask_i | input | NUM_ENTRIES | Slots to drop (squash) |
| wake_o | output | NUM_ENTRIES*NUM_SRCS | Per-source wake pulse, bit e*NUM_SRCS+s |
| ready_o | output | NUM_ENTRIES | Slot holds an instruction with all sources ready |
| sb_ready_o | output | NUM_PREGS | Scoreboard, one bit per physical register |
| err_o | output | 1 | New producer claims a register that still has waiters |

## Verification
The assertions check on every cycle that scoreboard bits follow completions and claims one edge later. They also check that wake pulses appear only with an in-range completion, that the error line appears only with an insert, and that killed slots fall silent. Other behaviour can only be shown by the bench's scenarios: the scoreboard re-check at insert, the tie between a completion and an insert of the same tag, the precedence of an insert over a kill, and the exact set of slots woken by a broadcast. The bench compares these against a per-cycle model under both directed and random traffic.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  localparam int unsigned SBW_ENTRIES = 16;
  localparam int unsigned SBW_SRCS    = 2;
  localparam int unsigned SBW_PREGS   = 64;
endpackage

// File: rtl/sbw_scoreboard.sv
module sbw_scoreboard #(
  parameter int unsigned NUM_PREGS = 64,
  localparam int unsigned PW = $clog2(NUM_PREGS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_i,
  input  logic [PW-1:0]        set_idx_i,
  input  logic                 clr_i,
  input  logic [PW-1:0]        clr_idx_i,
  output logic [NUM_PREGS-1:0] rdy_o
);
  logic [NUM_PREGS-1:0] set_vec, clr_vec, rdy_d;

  always_comb begin
    set_vec = set_i ? (NUM_PREGS'(1) << set_idx_i) : '0;
    clr_vec = clr_i ? (NUM_PREGS'(1) << clr_idx_i) : '0;
    rdy_d   = (rdy_o | set_vec) & ~clr_vec;  // a new claim beats a completion
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rdy_o <= '0;
    else         rdy_o <= rdy_d;
endmodule

// File: rtl/sbw_cam_entry.sv
module sbw_cam_entry #(
  parameter int unsigned NUM_SRCS = 2,
  parameter int unsigned TAG_W    = 7
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      alloc_i,
  input  logic [NUM_SRCS*TAG_W-1:0] tags_i,
  input  logic [NUM_SRCS-1:0]       rdy_init_i,
  input  logic                      kill_i,
  input  logic                      cmpl_i,
  input  logic [TAG_W-1:0]          cmpl_tag_i,
  input  logic [TAG_W-1:0]          probe_tag_i,
  output logic [NUM_SRCS-1:0]       wake_o,
  output logic                      ready_o,
  output logic                      probe_hit_o
);
  logic                      valid_q;
  logic [NUM_SRCS*TAG_W-1:0] tag_q;
  logic [NUM_SRCS-1:0]       rdy_q, hit;

  for (genvar s = 0; s < NUM_SRCS; s++) begin : g_src
    logic [TAG_W-1:0] t;
    assign t         = tag_q[s*TAG_W +: TAG_W];
    assign wake_o[s] = valid_q & ~kill_i & ~rdy_q[s] & cmpl_i & (t == cmpl_tag_i);
    assign hit[s]    = valid_q & ~rdy_q[s] & (t == probe_tag_i);
  end

  assign probe_hit_o = |hit;
  assign ready_o     = valid_q & (&rdy_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      rdy_q   <= '1;
    end else if (alloc_i) begin
      valid_q <= 1'b1;
      tag_q   <= tags_i;
      rdy_q   <= rdy_init_i;
    end else if (kill_i) begin
      valid_q <= 1'b0;
      rdy_q   <= '1;
    end else begin
      rdy_q   <= rdy_q | wake_o;
    end
  end
endmodule

// File: rtl/sbw_wakeup_unit.sv
module sbw_wakeup_unit
  import sbw_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = SBW_ENTRIES,
  parameter int unsigned NUM_SRCS    = SBW_SRCS,
  parameter int unsigned NUM_PREGS   = SBW_PREGS,
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES),
  localparam int unsigned PW    = $clog2(NUM_PREGS),
  localparam int unsigned TAG_W = PW + 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          alloc_valid_i,
  input  logic [IDX_W-1:0]              alloc_idx_i,
  input  logic [TAG_W-1:0]              alloc_dst_i,
  input  logic [NUM_SRCS*TAG_W-1:0]     alloc_src_tags_i,
  input  logic [NUM_SRCS-1:0]           alloc_src_unrdy_i,
  input  logic                          cmpl_valid_i,
  input  logic [TAG_W-1:0]              cmpl_tag_i,
  input  logic [NUM_ENTRIES-1:0]        kill_mask_i,
  output logic [NUM_ENTRIES*NUM_SRCS-1:0] wake_o,
  output logic [NUM_ENTRIES-1:0]        ready_o,
  output logic [NUM_PREGS-1:0]          sb_ready_o,
  output logic                          err_o
);
  logic                   dst_in, cmpl_in;
  logic [NUM_SRCS-1:0]    init_rdy;
  logic [NUM_ENTRIES-1:0] dst_hit;

  assign dst_in  = alloc_valid_i && (alloc_dst_i < TAG_W'(NUM_PREGS));
  assign cmpl_in = cmpl_valid_i && (cmpl_tag_i < TAG_W'(NUM_PREGS));

  sbw_scoreboard #(.NUM_PREGS(NUM_PREGS)) u_sb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (cmpl_in),
    .set_idx_i (cmpl_tag_i[PW-1:0]),
    .clr_i     (dst_in),
    .clr_idx_i (alloc_dst_i[PW-1:0]),
    .rdy_o     (sb_ready_o)
  );

  // Scoreboard re-check at insert, including a completion landing this cycle
  for (genvar s = 0; s < NUM_SRCS; s++) begin : g_init
    logic [TAG_W-1:0] t;
    logic             in_rng;
    assign t      = alloc_src_tags_i[s*TAG_W +: TAG_W];
    assign in_rng = t < TAG_W'(NUM_PREGS);
    assign init_rdy[s] = ~(alloc_src_unrdy_i[s] & in_rng & ~sb_ready_o[t[PW-1:0]]
                           & ~(cmpl_in & (cmpl_tag_i == t)));
  end

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    sbw_cam_entry #(.NUM_SRCS(NUM_SRCS), .TAG_W(TAG_W)) u_ent (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .alloc_i     (alloc_valid_i && (alloc_idx_i == IDX_W'(e))),
      .tags_i      (alloc_src_tags_i),
      .rdy_init_i  (init_rdy),
      .kill_i      (kill_mask_i[e]),
      .cmpl_i      (cmpl_in),
      .cmpl_tag_i  (cmpl_tag_i),
      .probe_tag_i (alloc_dst_i),
      .wake_o      (wake_o[e*NUM_SRCS +: NUM_SRCS]),
      .ready_o     (ready_o[e]),
      .probe_hit_o (dst_hit[e])
    );
  end

  assign err_o = dst_in & (|dst_hit);
endmodule

// File: rtl/sbw_wakeup_checker.sv
module sbw_wakeup_checker #(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned NUM_SRCS    = 2,
  parameter int unsigned NUM_PREGS   = 64,
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES),
  localparam int unsigned PW    = $clog2(NUM_PREGS),
  localparam int unsigned TAG_W = PW + 1
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          alloc_valid_i,
  input logic [IDX_W-1:0]              alloc_idx_i,
  input logic [TAG_W-1:0]              alloc_dst_i,
  input logic [NUM_SRCS*TAG_W-1:0]     alloc_src_tags_i,
  input logic [NUM_SRCS-1:0]           alloc_src_unrdy_i,
  input logic                          cmpl_valid_i,
  input logic [TAG_W-1:0]              cmpl_tag_i,
  input logic [NUM_ENTRIES-1:0]        kill_mask_i,
  input logic [NUM_ENTRIES*NUM_SRCS-1:0] wake_o,
  input logic [NUM_ENTRIES-1:0]        ready_o,
  input logic [NUM_PREGS-1:0]          sb_ready_o,
  input logic                          err_o
);
  logic dst_in, cmpl_in;
  logic [NUM_ENTRIES-1:0] alloc_oh;
  assign dst_in   = alloc_valid_i && (alloc_dst_i < TAG_W'(NUM_PREGS));
  assign cmpl_in  = cmpl_valid_i && (cmpl_tag_i < TAG_W'(NUM_PREGS));
  assign alloc_oh = alloc_valid_i ? (NUM_ENTRIES'(1) << alloc_idx_i) : '0;

  assert_claim_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_in |=> !sb_ready_o[$past(alloc_dst_i[PW-1:0])]);

  assert_cmpl_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_in && !(dst_in && alloc_dst_i == cmpl_tag_i))
    |=> sb_ready_o[$past(cmpl_tag_i[PW-1:0])]);

  assert_out_of_range_silent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmpl_in |-> (wake_o == '0));

  assert_wake_needs_cmpl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o != '0) |-> cmpl_valid_i);

  assert_kill_empties_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kill_mask_i != '0) |=> ((ready_o & $past(kill_mask_i & ~alloc_oh)) == '0));

  assert_err_needs_insert_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> dst_in);
endmodule

bind sbw_wakeup_unit sbw_wakeup_checker #(
  .NUM_ENTRIES(NUM_ENTRIES), .NUM_SRCS(NUM_SRCS), .NUM_PREGS(NUM_PREGS)
) i_chk (.*);

// File: tb/test_sbw_wakeup_unit.sv
`timescale 1ns/1ps
module test_sbw_wakeup_unit;
  localparam int NE = 16, NS = 2, NP = 64, TW = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic           a_v;
  logic [3:0]     a_idx;
  logic [TW-1:0]  a_dst;
  logic [NS*TW-1:0] a_src;
  logic [NS-1:0]  a_unr;
  logic           c_v;
  logic [TW-1:0]  c_tag;
  logic [NE-1:0]  k_mask;
  logic [NE*NS-1:0] wake;
  logic [NE-1:0]  rdy;
  logic [NP-1:0]  sb;
  logic           err;

  sbw_wakeup_unit i_sbw_wakeup_unit (
    .clk_i(clk), .rst_ni(rst_n), .alloc_valid_i(a_v), .alloc_idx_i(a_idx),
    .alloc_dst_i(a_dst), .alloc_src_tags_i(a_src), .alloc_src_unrdy_i(a_unr),
    .cmpl_valid_i(c_v), .cmpl_tag_i(c_tag), .kill_mask_i(k_mask),
    .wake_o(wake), .ready_o(rdy), .sb_ready_o(sb), .err_o(err));

  int n_cmp = 0, n_bad = 0;
  logic [NP-1:0]   m_sb;
  logic [NE-1:0]   m_vld;
  logic [NS-1:0]   m_rdy [NE];
  logic [TW-1:0]   m_tag [NE][NS];

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [NE*NS-1:0] exp_wake();
    logic [NE*NS-1:0] w = '0;
    if (c_v && c_tag < NP)
      for (int e = 0; e < NE; e++)
        for (int s = 0; s < NS; s++)
          w[e*NS+s] = m_vld[e] & ~k_mask[e] & ~m_rdy[e][s] & (m_tag[e][s] == c_tag);
    return w;
  endfunction

  function automatic logic exp_err();
    logic h = 1'b0;
    if (a_v && a_dst < NP)
      for (int e = 0; e < NE; e++)
        for (int s = 0; s < NS; s++)
          if (m_vld[e] && !m_rdy[e][s] && m_tag[e][s] == a_dst) h = 1'b1;
    return h;
  endfunction

  function automatic logic [NE-1:0] exp_ready();
    logic [NE-1:0] r;
    for (int e = 0; e < NE; e++) r[e] = m_vld[e] & (&m_rdy[e]);
    return r;
  endfunction

  task automatic model_update();
    logic [NE*NS-1:0] w = exp_wake();
    logic [NS-1:0] ir;
    for (int s = 0; s < NS; s++) begin
      logic [TW-1:0] t = a_src[s*TW +: TW];
      ir[s] = !(a_unr[s] && t < NP && !m_sb[t[5:0]] && !(c_v && c_tag == t));
    end
    for (int e = 0; e < NE; e++) begin
      if (a_v && a_idx == e) begin
        m_vld[e] = 1'b1; m_rdy[e] = ir;
        for (int s = 0; s < NS; s++) m_tag[e][s] = a_src[s*TW +: TW];
      end else if (k_mask[e]) begin
        m_vld[e] = 1'b0; m_rdy[e] = '1;
      end else m_rdy[e] = m_rdy[e] | w[e*NS +: NS];
    end
    if (c_v && c_tag < NP) m_sb[c_tag[5:0]] = 1'b1;
    if (a_v && a_dst < NP) m_sb[a_dst[5:0]] = 1'b0;
  endtask

  task automatic idle();
    a_v = 0; a_idx = 0; a_dst = 0; a_src = 0; a_unr = 0; c_v = 0; c_tag = 0; k_mask = 0;
  endtask

  task automatic step();
    #1;
    chk("R6 wake", 64'(wake), 64'(exp_wake()));
    chk("R9 err", 64'(err), 64'(exp_err()));
    @(posedge clk);
    model_update();
    #1;
    chk("R7 ready", 64'(rdy), 64'(exp_ready()));
    chk("R3 scoreboard", sb, m_sb);
    @(negedge clk);
    idle();
  endtask

  task automatic ins(int idx, int dst, int s0, int s1, logic [1:0] unr);
    a_v = 1; a_idx = 4'(idx); a_dst = TW'(dst);
    a_src = {TW'(s1), TW'(s0)}; a_unr = unr;
  endtask

  task automatic done();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    done();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    idle();
    m_sb = '0; m_vld = '0;
    for (int e = 0; e < NE; e++) begin
      m_rdy[e] = '1;
      for (int s = 0; s < NS; s++) m_tag[e][s] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset scoreboard", sb, 64'd0);
    chk("R1 reset ready", 64'(rdy), 64'd0);
    @(negedge clk);

    // R4/R6/R7: wait on 10, src1 flagged ready
    ins(0, 1, 10, 11, 2'b01); step();
    chk("R4 flagged-ready src still waits on other", 64'(rdy[0]), 64'd0);
    c_v = 1; c_tag = 10;
    #1 chk("R6 wake slot0 src0", 64'(wake[1:0]), 64'd1);
    step();
    chk("R7 ready after wake", 64'(rdy[0]), 64'd1);

    // R4: scoreboard already set at insert
    c_v = 1; c_tag = 20; step();
    ins(1, 2, 20, 21, 2'b11); a_unr = 2'b01; step();
    chk("R4 scoreboard re-check", 64'(rdy[1]), 64'd1);

    // R5: out-of-range tags
    ins(2, 100, 70, 90, 2'b11); step();
    chk("R5 out-of-range src ready", 64'(rdy[2]), 64'd1);
    chk("R5 out-of-range dst", sb, m_sb);
    c_v = 1; c_tag = 70;
    #1 chk("R5 out-of-range cmpl wakes nothing", 64'(wake), 64'd0);
    step();

    // R10: same-cycle completion and insert
    ins(3, 3, 30, 31, 2'b01); c_v = 1; c_tag = 30; step();
    chk("R10 same-cycle tie ready", 64'(rdy[3]), 64'd1);

    // R9: claim while waiters exist; R8: kill
    ins(4, 4, 40, 41, 2'b01); step();
    ins(5, 40, 0, 0, 2'b00);
    #1 chk("R9 err on claim", 64'(err), 64'd1);
    step();
    k_mask = 16'h0010; step();
    chk("R8 killed not ready", 64'(rdy[4]), 64'd0);
    c_v = 1; c_tag = 40;
    #1 chk("R8 killed no wake", 64'(wake[9:8]), 64'd0);
    step();
    // R8: insert beats kill on the same slot
    ins(6, 6, 0, 0, 2'b00); k_mask = 16'h0040; step();
    chk("R8 insert beats kill", 64'(rdy[6]), 64'd1);

    // R2: claim beats completion of the same tag
    ins(7, 50, 0, 0, 2'b00); c_v = 1; c_tag = 50; step();
    chk("R2 claim beats completion", 64'(sb[50]), 64'd0);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 1) == 1) begin
        ins($urandom_range(0, NE-1), $urandom_range(0, 79), $urandom_range(0, 79),
            $urandom_range(0, 79), 2'($urandom_range(0, 3)));
      end
      if ($urandom_range(0, 1) == 1) begin
        c_v = 1;
        if ($urandom_range(0, 1) == 1) begin
          int e = $urandom_range(0, NE-1);
          c_tag = m_tag[e][$urandom_range(0, NS-1)];
        end else c_tag = TW'($urandom_range(0, 79));
      end
      if ($urandom_range(0, 15) == 0) k_mask = NE'($urandom_range(0, 65535));
      step();
    end
    done();
  end
endmodule